// File: doc/BRIEF.md
# Double-Buffered Cross-Correlation Cell Group

This block correlates two complex sample streams for one frequency channel at a time. An input beat carries one complex sample of a shared reference stream (X) and one complex sample of a companion stream (Y) for each of several cells. Sixteen consecutive beats make up one set, with one value per element. Each cell keeps its set of X values and its set of Y values in local storage. It then forms all 16 by 16 products x_i · conj(y_j) and adds them into 256 complex accumulators. Every loaded value is used in sixteen products, so each multiplier needs one sixteenth of the input bandwidth that a streaming systolic array would need.

Each set store has two banks. The next set loads into the idle bank while the product pass runs on the other one. A channel block is a run of NBLK sets. The first set of a block overwrites the accumulators instead of adding to them. After the last set the whole accumulator array streams out, one entry per cycle, together with the channel number. The cells in a group share the X bus and the control logic, and each cell has its own Y lane.

Top module: `cc_group`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0.
- R2: A beat is taken on a rising edge where `in_valid` and `in_ready` are both 1. Accepted beats number the elements 0..NS-1 in turn, and NS beats complete one set.
- R3: For every set, each cell adds, for every row i and column j, re = xr_i·yr_j + xi_i·yi_j and im = xi_i·yr_j − xr_i·yi_j to accumulator (i, j).
- R4: Loading one bank overlaps the product pass on the other bank. `in_ready` goes low only while both banks hold sets that are not yet processed, and with continuous input it does go low.
- R5: A block is NBLK consecutive sets. The first set of each block starts the accumulators from zero, so the readout of a block depends only on that block's samples.
- R6: Accumulators are AW = 2·SW+1+log2(NBLK) bits wide, two's complement. A block of full-scale samples (−128 and 127 with SW=8) reads out exactly and does not wrap.
- R7: After the last set of a block, NS·NS entries are output on consecutive cycles with `out_valid` = 1. They come in row-major order: `out_row` (i) is the outer index, `out_col` (j) is the inner index, starting at (0,0).
- R8: During a readout, `out_chan` equals the `in_chan` that was presented with the final beat of the block.
- R9: Cell c reads its Y sample from bits [c·SW +: SW] of `in_yr`/`in_yi`. Its result is at `out_acc[c·2·AW +: 2·AW]`, with the real part in the low AW bits and the imaginary part in the high AW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_xr | input | SW | Shared X sample, real part |
| in_xi | input | SW | Shared X sample, imaginary part |
| in_yr | input | NCELL·SW | Per-cell Y samples, real parts |
| in_yi | input | NCELL·SW | Per-cell Y samples, imaginary parts |
| in_chan | input | CHW | Channel number of the current beat |
| out_valid | output | 1 | Readout entry valid |
| out_chan | output | CHW | Channel of the block being read out |
| out_row | output | log2(NS) | Row index i of the entry |
| out_col | output | log2(NS) | Column index j of the entry |
| out_acc | output | NCELL·2·AW | Accumulator values of all cells for entry (i, j) |

## Verification
A wrong bank pointer or set counter inside the block does not show up until the readout at the end of the channel block. At that point all 256 entries of every cell disagree with the products of the samples that were sent, about NBLK·(NS+1) cycles after the fault. A missing accumulator clear shows up in the next block as values that carry over from the previous one. A stuck bank-full flag stops `in_ready` within one set. Overflow at full scale appears as flipped signs in the dedicated full-scale block.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PASS  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_READ  = 2'd3
  } cc_phase_e;
endpackage

// File: rtl/cc_fill_ctrl.sv
module cc_fill_ctrl #(
  parameter int NS   = 16,
  parameter int NBLK = 256,
  parameter int CHW  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [CHW-1:0]           in_chan,
  input  logic                     rel_en,
  input  logic                     rel_bank,
  output logic                     in_ready,
  output logic                     wr_en,
  output logic                     wr_bank,
  output logic [$clog2(NS)-1:0]    wr_idx,
  output logic [1:0]               full,
  output logic [1:0]               first_flag,
  output logic [1:0]               last_flag,
  output logic [1:0][CHW-1:0]      chan_bank
);
  localparam int IW = $clog2(NS);
  localparam int BW = $clog2(NBLK);

  logic          fb;
  logic [IW-1:0] wc;
  logic [BW-1:0] sc;

  assign in_ready = !full[fb];
  assign wr_en    = in_valid && in_ready;
  assign wr_bank  = fb;
  assign wr_idx   = wc;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb         <= 1'b0;
      wc         <= '0;
      sc         <= '0;
      full       <= 2'b00;
      first_flag <= 2'b00;
      last_flag  <= 2'b00;
      chan_bank  <= '0;
    end else begin
      if (rel_en) full[rel_bank] <= 1'b0;
      if (wr_en) begin
        if (wc == IW'(NS - 1)) begin
          full[fb]       <= 1'b1;
          first_flag[fb] <= (sc == '0);
          last_flag[fb]  <= (sc == BW'(NBLK - 1));
          chan_bank[fb]  <= in_chan;
          fb             <= ~fb;
          wc             <= '0;
          sc             <= (sc == BW'(NBLK - 1)) ? '0 : sc + 1'b1;
        end else begin
          wc <= wc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cc_seq.sv
module cc_seq
  import cc_pkg::*;
#(
  parameter int NS  = 16,
  parameter int CHW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             full,
  input  logic [1:0]             first_flag,
  input  logic [1:0]             last_flag,
  input  logic [1:0][CHW-1:0]    chan_bank,
  output logic                   issue_en,
  output logic                   cmp_bank,
  output logic                   rel_en,
  output logic                   rel_bank,
  output logic [$clog2(NS)-1:0]  rd_row,
  output logic                   s1_valid,
  output logic [$clog2(NS)-1:0]  s1_row,
  output logic                   s1_first,
  output logic                   s1_bank,
  output logic                   r1_valid,
  output logic [$clog2(NS)-1:0]  r1_row,
  output logic [$clog2(NS)-1:0]  r1_col,
  output logic [CHW-1:0]         rd_chan
);
  localparam int IW = $clog2(NS);

  cc_phase_e     phase;
  logic          cb;
  logic [IW-1:0] row, ri, rj;
  logic          first_r, last_r;

  always_comb begin
    issue_en = (phase == PH_PASS);
    rel_en   = issue_en && (row == IW'(NS - 1));
    rel_bank = cb;
    cmp_bank = cb;
    rd_row   = (phase == PH_READ) ? ri : row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cb       <= 1'b0;
      row      <= '0;
      ri       <= '0;
      rj       <= '0;
      first_r  <= 1'b0;
      last_r   <= 1'b0;
      s1_valid <= 1'b0;
      s1_row   <= '0;
      s1_first <= 1'b0;
      s1_bank  <= 1'b0;
      r1_valid <= 1'b0;
      r1_row   <= '0;
      r1_col   <= '0;
      rd_chan  <= '0;
    end else begin
      s1_valid <= issue_en;
      s1_row   <= row;
      s1_first <= first_r;
      s1_bank  <= cb;
      r1_valid <= (phase == PH_READ);
      r1_row   <= ri;
      r1_col   <= rj;
      case (phase)
        PH_IDLE: if (full[cb]) begin
          phase   <= PH_PASS;
          row     <= '0;
          first_r <= first_flag[cb];
          last_r  <= last_flag[cb];
          if (last_flag[cb]) rd_chan <= chan_bank[cb];
        end
        PH_PASS: begin
          row <= row + 1'b1;
          if (row == IW'(NS - 1)) begin
            cb    <= ~cb;
            phase <= last_r ? PH_DRAIN : PH_IDLE;
          end
        end
        PH_DRAIN: begin
          phase <= PH_READ;
          ri    <= '0;
          rj    <= '0;
        end
        PH_READ: begin
          rj <= rj + 1'b1;
          if (rj == IW'(NS - 1)) begin
            ri <= ri + 1'b1;
            if (ri == IW'(NS - 1)) phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_PASS_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PASS) |-> full[cb]); // R4
  AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ) |-> !s1_valid); // R7
endmodule

// File: rtl/cc_cell.sv
module cc_cell #(
  parameter int NS = 16,
  parameter int SW = 8,
  parameter int AW = 25
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_bank,
  input  logic [$clog2(NS)-1:0]  wr_idx,
  input  logic signed [SW-1:0]   in_xr,
  input  logic signed [SW-1:0]   in_xi,
  input  logic signed [SW-1:0]   in_yr,
  input  logic signed [SW-1:0]   in_yi,
  input  logic [$clog2(NS)-1:0]  rd_row,
  input  logic                   s1_valid,
  input  logic [$clog2(NS)-1:0]  s1_row,
  input  logic                   s1_first,
  input  logic                   s1_bank,
  input  logic [$clog2(NS)-1:0]  r1_col,
  output logic [AW-1:0]          out_re,
  output logic [AW-1:0]          out_im
);
  localparam int PW = 2 * SW;
  localparam int XW = AW - PW;

  logic signed [SW-1:0] xr_m [0:1][0:NS-1];
  logic signed [SW-1:0] xi_m [0:1][0:NS-1];
  logic signed [SW-1:0] yr_m [0:1][0:NS-1];
  logic signed [SW-1:0] yi_m [0:1][0:NS-1];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      xr_m[wr_bank][wr_idx] <= in_xr;
      xi_m[wr_bank][wr_idx] <= in_xi;
      yr_m[wr_bank][wr_idx] <= in_yr;
      yi_m[wr_bank][wr_idx] <= in_yi;
    end
  end

  logic signed [SW-1:0] xs_re, xs_im;
  assign xs_re = xr_m[s1_bank][s1_row];
  assign xs_im = xi_m[s1_bank][s1_row];

  logic [NS-1:0][2*AW-1:0] q_all;

  for (genvar j = 0; j < NS; j++) begin : g_col
    logic [2*AW-1:0]      acc_m [NS];
    logic [2*AW-1:0]      q_j;
    logic signed [PW-1:0] m_rr, m_ii, m_ir, m_ri;
    logic [AW-1:0]        p_re, p_im, b_re, b_im;
    logic [AW:0]          e_re, e_im;

    always_comb begin
      m_rr = xs_re * yr_m[s1_bank][j];
      m_ii = xs_im * yi_m[s1_bank][j];
      m_ir = xs_im * yr_m[s1_bank][j];
      m_ri = xs_re * yi_m[s1_bank][j];
      p_re = {{XW{m_rr[PW-1]}}, m_rr} + {{XW{m_ii[PW-1]}}, m_ii};
      p_im = {{XW{m_ir[PW-1]}}, m_ir} - {{XW{m_ri[PW-1]}}, m_ri};
      b_re = s1_first ? '0 : q_j[AW-1:0];
      b_im = s1_first ? '0 : q_j[2*AW-1:AW];
      e_re = {b_re[AW-1], b_re} + {p_re[AW-1], p_re};
      e_im = {b_im[AW-1], b_im} + {p_im[AW-1], p_im};
    end

    always_ff @(posedge clk) begin
      q_j <= acc_m[rd_row];
      if (s1_valid) acc_m[s1_row] <= {e_im[AW-1:0], e_re[AW-1:0]};
    end

    assign q_all[j] = q_j;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      s1_valid |-> (e_re[AW] == e_re[AW-1]) && (e_im[AW] == e_im[AW-1])); // R6
  end

  assign out_re = q_all[r1_col][AW-1:0];
  assign out_im = q_all[r1_col][2*AW-1:AW];
endmodule

// File: rtl/cc_group.sv
module cc_group #(
  parameter int NCELL = 4,
  parameter int NS    = 16,
  parameter int SW    = 8,
  parameter int NBLK  = 256,
  parameter int CHW   = 8
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic [SW-1:0]                               in_xr,
  input  logic [SW-1:0]                               in_xi,
  input  logic [NCELL*SW-1:0]                         in_yr,
  input  logic [NCELL*SW-1:0]                         in_yi,
  input  logic [CHW-1:0]                              in_chan,
  output logic                                        out_valid,
  output logic [CHW-1:0]                              out_chan,
  output logic [$clog2(NS)-1:0]                       out_row,
  output logic [$clog2(NS)-1:0]                       out_col,
  output logic [NCELL*2*(2*SW+1+$clog2(NBLK))-1:0]    out_acc
);
  localparam int IW = $clog2(NS);
  localparam int AW = 2 * SW + 1 + $clog2(NBLK);

  logic              wr_en, wr_bank, rel_en, rel_bank, issue_en, cmp_bank;
  logic [IW-1:0]     wr_idx, rd_row, s1_row, r1_row, r1_col;
  logic [1:0]        full, first_flag, last_flag;
  logic [1:0][CHW-1:0] chan_bank;
  logic              s1_valid, s1_first, s1_bank, r1_valid;
  logic [CHW-1:0]    rd_chan;
  logic [NCELL-1:0][2*AW-1:0] cell_acc;

  cc_fill_ctrl #(.NS(NS), .NBLK(NBLK), .CHW(CHW)) fill_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .rel_en(rel_en), .rel_bank(rel_bank), .in_ready(in_ready),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .full(full),
    .first_flag(first_flag), .last_flag(last_flag), .chan_bank(chan_bank)
  );

  cc_seq #(.NS(NS), .CHW(CHW)) seq_i (
    .clk(clk), .rst(rst), .full(full), .first_flag(first_flag),
    .last_flag(last_flag), .chan_bank(chan_bank), .issue_en(issue_en),
    .cmp_bank(cmp_bank), .rel_en(rel_en), .rel_bank(rel_bank),
    .rd_row(rd_row), .s1_valid(s1_valid), .s1_row(s1_row),
    .s1_first(s1_first), .s1_bank(s1_bank), .r1_valid(r1_valid),
    .r1_row(r1_row), .r1_col(r1_col), .rd_chan(rd_chan)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic [AW-1:0] c_re, c_im;
    cc_cell #(.NS(NS), .SW(SW), .AW(AW)) cell_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
      .in_xr(in_xr), .in_xi(in_xi),
      .in_yr(in_yr[c*SW +: SW]), .in_yi(in_yi[c*SW +: SW]),
      .rd_row(rd_row), .s1_valid(s1_valid), .s1_row(s1_row),
      .s1_first(s1_first), .s1_bank(s1_bank), .r1_col(r1_col),
      .out_re(c_re), .out_im(c_im)
    );
    assign cell_acc[c] = {c_im, c_re};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      out_acc   <= '0;
    end else begin
      out_valid <= r1_valid;
      if (r1_valid) begin
        out_row  <= r1_row;
        out_col  <= r1_col;
        out_chan <= rd_chan;
        out_acc  <= cell_acc;
      end
    end
  end

  AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !(issue_en && (wr_bank == cmp_bank))); // R4
  AST_READY_BOTH_FULL: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (full == 2'b11)); // R4
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |->
      ({out_row, out_col} == $past({out_row, out_col}) + 1'b1)); // R7
  AST_READ_START: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_row == '0) && (out_col == '0)); // R7
endmodule

// File: tb/cc_group_tb_top.sv
`timescale 1ns/1ps
module cc_group_tb_top;
  localparam int NCELL = 4;
  localparam int NS    = 16;
  localparam int SW    = 8;
  localparam int NBLK  = 256;
  localparam int CHW   = 8;
  localparam int IW    = $clog2(NS);
  localparam int AW    = 2 * SW + 1 + $clog2(NBLK);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SW-1:0] in_xr = '0, in_xi = '0;
  logic [NCELL*SW-1:0] in_yr = '0, in_yi = '0;
  logic [CHW-1:0] in_chan = '0;
  logic out_valid;
  logic [CHW-1:0] out_chan;
  logic [IW-1:0] out_row, out_col;
  logic [NCELL*2*AW-1:0] out_acc;

  cc_group #(.NCELL(NCELL), .NS(NS), .SW(SW), .NBLK(NBLK), .CHW(CHW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_xr(in_xr), .in_xi(in_xi), .in_yr(in_yr), .in_yi(in_yi),
    .in_chan(in_chan), .out_valid(out_valid), .out_chan(out_chan),
    .out_row(out_row), .out_col(out_col), .out_acc(out_acc)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int stalls = 0;
  int rb     = 0;
  int ridx   = 0;
  int exp_re [2][NCELL][NS][NS];
  int exp_im [2][NCELL][NS][NS];
  int exp_chan [2];
  int sx_re [NS], sx_im [NS];
  int sy_re [NCELL][NS], sy_im [NCELL][NS];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic beat(input int k, input int chan);
    logic [NCELL*SW-1:0] yr, yi;
    @(negedge clk);
    for (int c = 0; c < NCELL; c++) begin
      yr[c*SW +: SW] = SW'(sy_re[c][k]);
      yi[c*SW +: SW] = SW'(sy_im[c][k]);
    end
    in_valid = 1'b1;
    in_xr = SW'(sx_re[k]);
    in_xi = SW'(sx_im[k]);
    in_yr = yr;
    in_yi = yi;
    in_chan = CHW'(chan);
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  // mode 0: random samples, mode 1: full-scale samples (R6)
  task automatic send_block(input int blk, input int chan, input int mode, input int gap_pct);
    int p;
    p = blk % 2;
    exp_chan[p] = chan;
    for (int c = 0; c < NCELL; c++)
      for (int i = 0; i < NS; i++)
        for (int j = 0; j < NS; j++) begin
          exp_re[p][c][i][j] = 0;
          exp_im[p][c][i][j] = 0;
        end
    for (int s = 0; s < NBLK; s++) begin
      for (int k = 0; k < NS; k++) begin
        if (mode == 1) begin
          sx_re[k] = -128;
          sx_im[k] = -128;
          for (int c = 0; c < NCELL; c++) begin
            sy_re[c][k] = -128;
            sy_im[c][k] = (c % 2 == 1) ? 127 : -128;
          end
        end else begin
          sx_re[k] = int'($urandom_range(0, 255)) - 128;
          sx_im[k] = int'($urandom_range(0, 255)) - 128;
          for (int c = 0; c < NCELL; c++) begin
            sy_re[c][k] = int'($urandom_range(0, 255)) - 128;
            sy_im[c][k] = int'($urandom_range(0, 255)) - 128;
          end
        end
      end
      for (int k = 0; k < NS; k++) begin
        if (int'($urandom_range(0, 99)) < gap_pct) begin
          @(negedge clk);
          in_valid = 1'b0;
          @(posedge clk);
        end
        beat(k, chan);
      end
      for (int c = 0; c < NCELL; c++)
        for (int i = 0; i < NS; i++)
          for (int j = 0; j < NS; j++) begin
            exp_re[p][c][i][j] += sx_re[i] * sy_re[c][j] + sx_im[i] * sy_im[c][j];
            exp_im[p][c][i][j] += sx_im[i] * sy_re[c][j] - sx_re[i] * sy_im[c][j];
          end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // readout monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        int p, ei, ej;
        string tg;
        logic signed [AW-1:0] vre, vim;
        p  = rb % 2;
        ei = ridx / NS;
        ej = ridx % NS;
        tg = (rb == 0) ? "R2 R3 R9" : (rb == 1) ? "R6 R9" : "R5 R9";
        chk({32'(out_row), 32'(out_col)} == {32'(ei), 32'(ej)},
            "R7 entry index", longint'(out_row) * NS + out_col, longint'(ridx));
        if (ridx == 0)
          chk(out_chan == CHW'(exp_chan[p]), "R8 channel", out_chan, exp_chan[p]);
        for (int c = 0; c < NCELL; c++) begin
          vre = out_acc[c*2*AW +: AW];
          vim = out_acc[c*2*AW + AW +: AW];
          chk(int'(vre) == exp_re[p][c][ei][ej], {tg, " real"}, vre, exp_re[p][c][ei][ej]);
          chk(int'(vim) == exp_im[p][c][ei][ej], {tg, " imag"}, vim, exp_im[p][c][ei][ej]);
        end
        ridx++;
        if (ridx == NS * NS) begin
          ridx = 0;
          rb++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=%0d readouts expected=3", rb);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee5));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready during reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid during reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    send_block(0, 17, 0, 0);
    chk(stalls > 0, "R4 ready dropped under continuous input", stalls, 1);
    send_block(1, 200, 1, 0);
    send_block(2, 5, 0, 30);

    while (rb < 3) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b0, "R7 idle after last readout", out_valid, 0);
    chk(rb == 3, "R7 readout count", rb, 3);
    summary();
    $finish;
  end
endmodule